// File: doc/BRIEF.md
# Paged Address Translator with Reference Tracking

This block maps a 16-bit virtual address onto a 16-bit physical address through a small table. The table has one entry per 4096-byte page, so 16 entries. The upper four address bits select an entry. Each entry holds a frame number, a resident flag and a reference bit. When the entry is resident, the frame number replaces the page bits and the low twelve bits pass through unchanged. When the entry is not resident, the block reports a page fault.

A lookup is requested with a valid strobe, and its result is registered, so it appears one clock later. Each successful lookup marks its entry as referenced. A bulk clear pulse, typically issued periodically by replacement logic elsewhere, zeroes every reference bit. The reference bits are brought out as a vector for that logic to read. A write port loads a frame number and resident flag into one entry and starts that entry's reference history afresh.

Top module: `pgx_translator`

## Requirements
- R1: After reset no entry is resident, every bit of `ref_bits` is 0 and `rsp_valid` is 0.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was 1.
- R3: For a resident page, `rsp_paddr` equals the entry's 4-bit frame number in bits 15:12, followed by the request's unchanged bits 11:0; the entry is chosen by request bits 15:12.
- R4: A lookup of a non-resident page gives `rsp_fault` = 1 and `rsp_paddr` = 0; a resident lookup gives `rsp_fault` = 0.
- R5: A successful lookup sets bit p of `ref_bits` (p = page number) at the same edge that produces its response.
- R6: A faulting lookup leaves `ref_bits` unchanged.
- R7: A `ref_clear` pulse zeroes all 16 reference bits at the next edge.
- R8: When `ref_clear` and a successful lookup of page p fall in the same cycle, bit p ends at 1 and all other bits end at 0.
- R9: A write sets the entry's frame number and resident flag and clears its reference bit; a lookup of that page in the following cycle uses the new contents.
- R10: When a write and a lookup target the same page in the same cycle, the lookup uses the entry's previous contents and the entry's reference bit ends at 0.
- R11: A cycle with no request, no write and no clear gives `rsp_valid` = 0 and leaves `ref_bits` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | 4 | Entry index to write |
| wr_frame | input | 4 | Frame number to store |
| wr_present | input | 1 | Resident flag to store |
| ref_clear | input | 1 | Zeroes all reference bits |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Lookup hit a non-resident page |
| rsp_paddr | output | 16 | Translated physical address |
| ref_bits | output | 16 | Reference bit of every entry, bit p for page p |

## Verification
The collisions are the hardest cases to reach: a clear, a write and a lookup all acting on one entry in a single cycle. These cases are only visible through the next edge's reference vector. The stimulus therefore drives the strobes together in one low clock phase. It first sets the other reference bits to 1, so that the clear has something to remove. It then checks the whole vector against a model, and checks the response that the collision's lookup returns, which must reflect the entry's old contents.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   typedef enum logic [1:0] {
      PGX_IDLE  = 2'd0,
      PGX_HIT   = 2'd1,
      PGX_FAULT = 2'd2
   } pgx_outcome_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
   parameter int PAGE_W  = 4,
   parameter int FRAME_W = 4,
   localparam int N_ENT  = 1 << PAGE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [PAGE_W-1:0]        wr_page,
   input  logic [FRAME_W-1:0]       wr_frame,
   input  logic                     wr_present,
   input  logic                     hit_en,
   input  logic [PAGE_W-1:0]        hit_page,
   input  logic                     ref_clear,
   output logic [N_ENT*FRAME_W-1:0] frame_tab,
   output logic [N_ENT-1:0]         pres_tab,
   output logic [N_ENT-1:0]         ref_tab
);
   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      logic [FRAME_W-1:0] frame_q;
      logic               pres_q;
      logic               ref_q;
      logic               wr_sel;
      logic               hit_sel;

      assign wr_sel  = wr_en  && (wr_page  == PAGE_W'(g));
      assign hit_sel = hit_en && (hit_page == PAGE_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            frame_q <= '0;
            pres_q  <= 1'b0;
            ref_q   <= 1'b0;
         end else if (wr_sel) begin
            frame_q <= wr_frame;
            pres_q  <= wr_present;
            ref_q   <= 1'b0;
         end else if (hit_sel) begin
            ref_q   <= 1'b1;
         end else if (ref_clear) begin
            ref_q   <= 1'b0;
         end
      end

      assign frame_tab[g*FRAME_W +: FRAME_W] = frame_q;
      assign pres_tab[g] = pres_q;
      assign ref_tab[g]  = ref_q;
   end
endmodule

// File: rtl/pgx_lookup.sv
module pgx_lookup
   import pgx_pkg::*;
#(
   parameter int VA_W    = 16,
   parameter int PA_W    = 16,
   parameter int OFF_W   = 12,
   localparam int PAGE_W  = VA_W - OFF_W,
   localparam int FRAME_W = PA_W - OFF_W,
   localparam int N_ENT   = 1 << PAGE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic [N_ENT*FRAME_W-1:0] frame_tab,
   input  logic [N_ENT-1:0]         pres_tab,
   output logic                     hit_en,
   output logic [PAGE_W-1:0]        hit_page,
   output logic                     rsp_valid,
   output logic                     rsp_fault,
   output logic [PA_W-1:0]          rsp_paddr
);
   logic [PAGE_W-1:0]  page;
   logic [OFF_W-1:0]   offset;
   logic [FRAME_W-1:0] frame;
   pgx_outcome_e       outcome;

   assign page   = req_vaddr[VA_W-1:OFF_W];
   assign offset = req_vaddr[OFF_W-1:0];
   assign frame  = frame_tab[page*FRAME_W +: FRAME_W];

   always_comb begin
      if (!req_valid)          outcome = PGX_IDLE;
      else if (pres_tab[page]) outcome = PGX_HIT;
      else                     outcome = PGX_FAULT;
   end

   assign hit_en   = (outcome == PGX_HIT);
   assign hit_page = page;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= (outcome != PGX_IDLE);
         rsp_fault <= (outcome == PGX_FAULT);
         rsp_paddr <= (outcome == PGX_HIT) ? {frame, offset} : '0;
      end
   end
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator #(
   parameter int VA_W  = 16,
   parameter int PA_W  = 16,
   parameter int OFF_W = 12,
   localparam int PAGE_W  = VA_W - OFF_W,
   localparam int FRAME_W = PA_W - OFF_W,
   localparam int N_ENT   = 1 << PAGE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic               wr_en,
   input  logic [PAGE_W-1:0]  wr_page,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic               wr_present,
   input  logic               ref_clear,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [N_ENT-1:0]   ref_bits
);
   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_off
      $error("pgx_translator: OFF_W must lie between 1 and VA_W-1");
   end
   if (PAGE_W > 8) begin : g_bad_pages
      $error("pgx_translator: table limited to 256 entries");
   end
   if (PA_W <= OFF_W) begin : g_bad_pa
      $error("pgx_translator: PA_W must exceed OFF_W");
   end

   logic [N_ENT*FRAME_W-1:0] frame_tab;
   logic [N_ENT-1:0]         pres_tab;
   logic                     hit_en;
   logic [PAGE_W-1:0]        hit_page;

   pgx_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) table_i (
      .clk, .rst_n,
      .wr_en, .wr_page, .wr_frame, .wr_present,
      .hit_en, .hit_page, .ref_clear,
      .frame_tab, .pres_tab, .ref_tab(ref_bits)
   );

   pgx_lookup #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) lookup_i (
      .clk, .rst_n, .req_valid, .req_vaddr,
      .frame_tab, .pres_tab,
      .hit_en, .hit_page,
      .rsp_valid, .rsp_fault, .rsp_paddr
   );
endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk #(
   parameter int VA_W  = 16,
   parameter int PA_W  = 16,
   parameter int OFF_W = 12,
   localparam int PAGE_W = VA_W - OFF_W,
   localparam int N_ENT  = 1 << PAGE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [VA_W-1:0]   req_vaddr,
   input logic              wr_en,
   input logic [PAGE_W-1:0] wr_page,
   input logic              ref_clear,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic [N_ENT-1:0]  ref_bits
);
   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_rsp_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_fault_has_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_valid && rsp_paddr == '0));

   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_clear && !req_valid && !wr_en) |=> (ref_bits == '0));

   assert_hit_marks_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(wr_en && wr_page == req_vaddr[VA_W-1:OFF_W]))
      |=> (rsp_fault || ref_bits[$past(req_vaddr[VA_W-1:OFF_W])]));

   assert_quiet_keeps_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !wr_en && !ref_clear) |=> $stable(ref_bits));
endmodule

bind pgx_translator pgx_translator_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) chk_i (
   .clk, .rst_n, .req_valid, .req_vaddr, .wr_en, .wr_page, .ref_clear,
   .rsp_valid, .rsp_fault, .rsp_paddr, .ref_bits
);

// File: tb/pgx_translator_tb_top.sv
module pgx_translator_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_vaddr = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_page = '0;
   logic [3:0]  wr_frame = '0;
   logic        wr_present = 1'b0;
   logic        ref_clear = 1'b0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [15:0] rsp_paddr;
   logic [15:0] ref_bits;

   always #10 clk = ~clk;

   pgx_translator dut_i (
      .clk, .rst_n, .req_valid, .req_vaddr,
      .wr_en, .wr_page, .wr_frame, .wr_present, .ref_clear,
      .rsp_valid, .rsp_fault, .rsp_paddr, .ref_bits
   );

   int n_checks = 0;
   int n_fail   = 0;

   logic [3:0]  m_frame [16];
   logic        m_pres  [16];
   logic [15:0] m_ref;

   typedef struct { logic fault; logic [15:0] paddr; string tag; } exp_t;
   exp_t sb_q[$];

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // one cycle: drive at negedge, update model, wait to next negedge, check refs
   task automatic step(input logic rq, input logic [15:0] va,
                       input logic we, input logic [3:0] wp, input logic [3:0] wf,
                       input logic wpres, input logic clr, input string tag);
      exp_t e;
      logic [3:0] p;
      p = va[15:12];
      req_valid = rq; req_vaddr = va;
      wr_en = we; wr_page = wp; wr_frame = wf; wr_present = wpres;
      ref_clear = clr;
      if (rq) begin
         e.fault = !m_pres[p];
         e.paddr = m_pres[p] ? {m_frame[p], va[11:0]} : 16'h0;
         e.tag   = tag;
         sb_q.push_back(e);
      end
      if (clr) m_ref = '0;
      if (rq && m_pres[p]) m_ref[p] = 1'b1;
      if (we) begin
         m_frame[wp] = wf; m_pres[wp] = wpres; m_ref[wp] = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; wr_en = 1'b0; ref_clear = 1'b0;
      check({tag, " ref_bits"}, 32'(ref_bits), 32'(m_ref));
   endtask

   // monitor: pops expected responses in order
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2: actual unexpected response expected none");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " fault"}, 32'(rsp_fault), 32'(e.fault));
            check({e.tag, " paddr"}, 32'(rsp_paddr), 32'(e.paddr));
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin m_frame[i] = '0; m_pres[i] = 1'b0; end
      m_ref = '0;
      repeat (3) @(negedge clk);
      check("R1 ref_bits at reset", 32'(ref_bits), 32'h0);
      check("R1 rsp_valid at reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: nothing resident after reset, so a lookup faults
      step(1, 16'h3456, 0, 0, 0, 0, 0, "R1 lookup after reset");

      // load table via write port (R9)
      step(0, 0, 1, 4'd0,  4'd9,  1, 0, "R9 write p0");
      step(0, 0, 1, 4'd1,  4'd1,  1, 0, "R9 write p1");
      step(0, 0, 1, 4'd2,  4'd14, 1, 0, "R9 write p2");
      step(0, 0, 1, 4'd11, 4'd4,  1, 0, "R9 write p11");
      step(0, 0, 1, 4'd6,  4'd8,  1, 0, "R9 write p6");
      step(0, 0, 1, 4'd12, 4'd7,  0, 0, "R9 write p12 absent");

      // R3/R5 translations, back-to-back (R2)
      step(1, 16'hBC2C, 0, 0, 0, 0, 0, "R3 R5 p11");
      step(1, 16'h00ED, 0, 0, 0, 0, 0, "R3 R5 p0");
      step(1, 16'h6901, 0, 0, 0, 0, 0, "R3 R5 p6");
      // R4/R6 faults
      step(1, 16'hC123, 0, 0, 0, 0, 0, "R4 R6 p12 absent");
      step(1, 16'hEA14, 0, 0, 0, 0, 0, "R4 R6 p14 absent");
      // R11 idle cycle
      step(0, 16'h1111, 0, 0, 0, 0, 0, "R11 idle");
      check("R11 rsp_valid idle", 32'(rsp_valid), 32'h0);
      // R7 clear alone
      step(0, 0, 0, 0, 0, 0, 1, "R7 clear");
      // set some bits, then R8 clear with hit on p2
      step(1, 16'h1FFF, 0, 0, 0, 0, 0, "R3 R5 p1");
      step(1, 16'h0000, 0, 0, 0, 0, 0, "R3 R5 p0 again");
      step(1, 16'h23A1, 0, 0, 0, 0, 1, "R8 clear with hit p2");
      // R9 rewrite p2 (ref cleared), lookup next cycle sees new frame
      step(0, 0, 1, 4'd2, 4'd5, 1, 0, "R9 rewrite p2");
      step(1, 16'h2ABC, 0, 0, 0, 0, 0, "R9 lookup new p2");
      // R10 write p6 absent with lookup of p6 same cycle
      step(1, 16'h6777, 1, 4'd6, 4'd3, 0, 0, "R10 write+lookup p6");
      step(1, 16'h6777, 0, 0, 0, 0, 0, "R10 p6 now absent");
      // write+clear together with a hit on another page
      step(1, 16'hB001, 1, 4'd0, 4'd2, 1, 1, "R8 R9 write clear hit");
      step(0, 0, 0, 0, 0, 0, 0, "R11 drain");
      check("R2 queue drained", 32'(sb_q.size()), 32'h0);
      finish_run();
   end
endmodule